// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block governs how instruction bundles move through a rename pipeline stage. Each cycle it takes one bundle of up to four lanes from decode. A lane carries a valid bit and a payload. The block passes as many lanes downstream as the credits allow. Three credit counts set the limit: free reorder-buffer slots, free issue-queue slots and free physical registers. When the stage cannot make progress, it parks the incoming bundles in a small skid store and raises a stall toward decode. Later it replays the parked bundles in arrival order, and only then does it accept fresh decode input again.

A flush from commit, either a squash pulse or a squash-in-progress level, discards all parked work and holds the stage in a squashing state until both signals drop. The block reports its state on a 3-bit status output. The register mapping itself sits outside this block. The block only decides which lanes are released and when.

Top module: `rn_stage_flow`

## Requirements
- R1: After reset the status is IDLE (code 0), `dec_stall` is 0 and `out_valid` is all zero.
- R2: Call each free count minus FB_DELAY (1 by default, floored at zero) an adjusted count. The lane budget is the smallest of LANES (4), the adjusted reorder-buffer count, the adjusted issue-queue count and `free_preg`. The block sends the first `budget` valid lanes of the source bundle, counted from lane 0 upward. Each sent lane appears on the next clock edge in the same lane position with its payload unchanged. Unsent lane positions read zero.
- R3: In IDLE, RUNNING or UNBLOCKING, a high `iew_stall` or `cmt_stall` causes the next status to be BLOCKED (code 2). In that case `dec_stall` goes to 1, no lane is sent, and any valid input bundle is stored.
- R4: If the lane budget is zero, the block behaves exactly as in R3.
- R5: While BLOCKED, each bundle with at least one valid lane is stored, `dec_stall` stays 1 and no lane is sent.
- R6: BLOCKED moves to UNBLOCKING (code 3) only when both stall inputs are low and the unadjusted `free_rob` and `free_iq` are both nonzero. `dec_stall` stays 1 across that move.
- R7: While bundles are stored, the oldest stored bundle is the source instead of decode input. `dec_stall` stays 1 while the store is non-empty. When the store empties, the status becomes RUNNING (code 1) and `dec_stall` becomes 0.
- R8: If a bundle is only partly sent, its unsent lanes are kept as the oldest stored bundle and sent first on the next cycle. The status becomes UNBLOCKING.
- R9: A high `squash` or `squash_busy` empties the store, sends nothing, discards the input and sets the status to SQUASHING (code 4) with `dec_stall` 0. The first cycle with both low returns the status to RUNNING, and that cycle's input is also discarded. Squashed bundles are never replayed.
- R10: With no stored bundle and no valid input lane, a running stage reports IDLE. After sending lanes from decode input with nothing left stored, it reports RUNNING.
- R11: The store holds up to SKID_DEPTH (4) bundles and replays them in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | LANES | Per-lane valid bits of the decode bundle |
| dec_data | input | LANES*DATA_W | Per-lane payloads, lane 0 in the low bits |
| iew_stall | input | 1 | Stall request from the issue/execute side |
| cmt_stall | input | 1 | Stall request from commit |
| free_rob | input | CNT_W | Free reorder-buffer slots |
| free_iq | input | CNT_W | Free issue-queue slots |
| free_preg | input | CNT_W | Free physical registers |
| squash | input | 1 | Flush pulse from commit |
| squash_busy | input | 1 | Flush still in progress |
| out_valid | output | LANES | Per-lane valid bits of the released bundle |
| out_data | output | LANES*DATA_W | Released payloads, zero in unsent lanes |
| dec_stall | output | 1 | Stall toward decode |
| status | output | 3 | Stage state code |

## Verification
The main release path is driven with full, sparse and single-lane bundles. Each credit input takes its turn as the limiting term, so a wrong minimum or a missing delay adjustment shows up as the wrong lane mask. Gapped valid patterns such as lanes 0 and 2 show whether the budget counts valid lanes or lane positions. A four-bundle backlog built under a commit stall, and a bundle split by a tight reorder-buffer count, tell in-order replay apart from reordering or from dropping unsent lanes. A flush over a stored bundle followed by an idle cycle shows that squashed work is never replayed.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCK   = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } rn_status_e;
endpackage

// File: rtl/rn_credit_calc.sv
module rn_credit_calc #(
    parameter int LANES    = 4,
    parameter int CNT_W    = 8,
    parameter int FB_DELAY = 1,
    localparam int BW      = $clog2(LANES + 1)
) (
    input  logic [CNT_W-1:0] free_rob,
    input  logic [CNT_W-1:0] free_iq,
    input  logic [CNT_W-1:0] free_preg,
    output logic [BW-1:0]    budget
);
    localparam logic [CNT_W-1:0] DLY = CNT_W'(FB_DELAY);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LANES);

    logic [CNT_W-1:0] adj_rob, adj_iq, m_a, m_b, m_c;

    always_comb begin
        adj_rob = (free_rob > DLY) ? free_rob - DLY : '0;
        adj_iq  = (free_iq  > DLY) ? free_iq  - DLY : '0;
        m_a     = (adj_rob < adj_iq) ? adj_rob : adj_iq;
        m_b     = (m_a < free_preg) ? m_a : free_preg;
        m_c     = (m_b < LIM) ? m_b : LIM;
        budget  = BW'(m_c);
    end
endmodule

// File: rtl/rn_lane_pick.sv
module rn_lane_pick #(
    parameter int LANES = 4,
    localparam int BW   = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] valid,
    input  logic [BW-1:0]    budget,
    output logic [LANES-1:0] send
);
    always_comb begin
        logic [BW:0] taken;
        taken = '0;
        for (int i = 0; i < LANES; i++) begin
            send[i] = valid[i] && (taken < {1'b0, budget});
            if (valid[i]) taken = taken + (BW+1)'(1);
        end
    end
endmodule

// File: rtl/rn_skid_buf.sv
module rn_skid_buf #(
    parameter int LANES  = 4,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int SCNT_W = $clog2(DEPTH + 1),
    localparam int BUS_W  = LANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [LANES-1:0]  push_valid,
    input  logic [BUS_W-1:0]  push_data,
    input  logic              pop,
    input  logic              head_wr,
    input  logic [LANES-1:0]  head_valid_new,
    output logic [LANES-1:0]  head_valid,
    output logic [BUS_W-1:0]  head_data,
    output logic              empty,
    output logic              full,
    output logic [SCNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
        logic [SCNT_W-1:0] cnt;
    } ptr_t;

    ptr_t r_q, r_d;
    logic [LANES-1:0] mem_v [DEPTH];
    logic [BUS_W-1:0] mem_d [DEPTH];
    logic             push_go, pop_go;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty      = (r_q.cnt == '0);
    assign full       = (r_q.cnt == SCNT_W'(DEPTH));
    assign count      = r_q.cnt;
    assign head_valid = mem_v[r_q.head];
    assign head_data  = mem_d[r_q.head];
    assign pop_go     = pop && !empty;
    assign push_go    = push && (!full || pop_go);

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d = '0;
        end else begin
            if (pop_go)  r_d.head = bump(r_q.head);
            if (push_go) r_d.tail = bump(r_q.tail);
            r_d.cnt = r_q.cnt + SCNT_W'(push_go) - SCNT_W'(pop_go);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_v[k] <= '0;
        end else if (!clear) begin
            if (head_wr && !empty) mem_v[r_q.head] <= head_valid_new;
            if (push_go) begin
                mem_v[r_q.tail] <= push_valid;
                mem_d[r_q.tail] <= push_data;
            end
        end
    end
endmodule

// File: rtl/rn_stage_flow.sv
module rn_stage_flow #(
    parameter int LANES      = 4,
    parameter int DATA_W     = 8,
    parameter int SKID_DEPTH = 4,
    parameter int CNT_W      = 8,
    parameter int FB_DELAY   = 1,
    localparam int BW        = $clog2(LANES + 1),
    localparam int SCNT_W    = $clog2(SKID_DEPTH + 1),
    localparam int BUS_W     = LANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  dec_valid,
    input  logic [BUS_W-1:0]  dec_data,
    input  logic              iew_stall,
    input  logic              cmt_stall,
    input  logic [CNT_W-1:0]  free_rob,
    input  logic [CNT_W-1:0]  free_iq,
    input  logic [CNT_W-1:0]  free_preg,
    input  logic              squash,
    input  logic              squash_busy,
    output logic [LANES-1:0]  out_valid,
    output logic [BUS_W-1:0]  out_data,
    output logic              dec_stall,
    output logic [2:0]        status
);
    import rn_pkg::*;

    typedef struct packed {
        rn_status_e       st;
        logic             stall;
        logic [LANES-1:0] ov;
        logic [BUS_W-1:0] od;
    } flow_t;

    flow_t r_q, r_d;

    logic [BW-1:0]     budget;
    logic [LANES-1:0]  src_valid, send, rem;
    logic [BUS_W-1:0]  src_data;
    logic              use_skid;
    logic              sk_clear, sk_push, sk_pop, sk_hwr;
    logic [LANES-1:0]  sk_push_valid, sk_head_valid;
    logic [BUS_W-1:0]  sk_head_data;
    logic              sk_empty, sk_full;
    logic [SCNT_W-1:0] sk_cnt;

    rn_credit_calc #(.LANES(LANES), .CNT_W(CNT_W), .FB_DELAY(FB_DELAY)) u_credit (
        .free_rob (free_rob),
        .free_iq  (free_iq),
        .free_preg(free_preg),
        .budget   (budget)
    );

    assign use_skid  = !sk_empty;
    assign src_valid = use_skid ? sk_head_valid : dec_valid;
    assign src_data  = use_skid ? sk_head_data  : dec_data;
    assign rem       = src_valid & ~send;

    rn_lane_pick #(.LANES(LANES)) u_pick (
        .valid (src_valid),
        .budget(budget),
        .send  (send)
    );

    rn_skid_buf #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(SKID_DEPTH)) u_skid (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (sk_clear),
        .push          (sk_push),
        .push_valid    (sk_push_valid),
        .push_data     (dec_data),
        .pop           (sk_pop),
        .head_wr       (sk_hwr),
        .head_valid_new(rem),
        .head_valid    (sk_head_valid),
        .head_data     (sk_head_data),
        .empty         (sk_empty),
        .full          (sk_full),
        .count         (sk_cnt)
    );

    always_comb begin
        logic              any_stall;
        logic              in_any;
        logic              push_acc;
        logic [SCNT_W:0]   cnt_next;
        any_stall     = iew_stall | cmt_stall;
        in_any        = |dec_valid;
        r_d           = r_q;
        r_d.ov        = '0;
        r_d.od        = '0;
        sk_clear      = 1'b0;
        sk_push       = 1'b0;
        sk_pop        = 1'b0;
        sk_hwr        = 1'b0;
        sk_push_valid = dec_valid;
        push_acc      = 1'b0;
        cnt_next      = '0;
        if (squash || squash_busy) begin
            sk_clear  = 1'b1;
            r_d.st    = ST_SQUASH;
            r_d.stall = 1'b0;
        end else begin
            case (r_q.st)
                ST_SQUASH: begin
                    r_d.st    = ST_RUN;
                    r_d.stall = 1'b0;
                end
                ST_BLOCK: begin
                    sk_push   = in_any;
                    r_d.stall = 1'b1;
                    if (!any_stall && free_rob != '0 && free_iq != '0)
                        r_d.st = ST_UNBLOCK;
                end
                default: begin
                    if (any_stall || budget == '0) begin
                        r_d.st    = ST_BLOCK;
                        r_d.stall = 1'b1;
                        sk_push   = in_any;
                    end else begin
                        r_d.ov = send;
                        for (int i = 0; i < LANES; i++)
                            if (send[i])
                                r_d.od[i*DATA_W +: DATA_W] = src_data[i*DATA_W +: DATA_W];
                        if (use_skid) begin
                            if (rem != '0) sk_hwr = 1'b1;
                            else           sk_pop = 1'b1;
                            sk_push = in_any;
                        end else if (rem != '0) begin
                            sk_push       = 1'b1;
                            sk_push_valid = rem;
                        end
                        push_acc = sk_push && (!sk_full || sk_pop);
                        cnt_next = {1'b0, sk_cnt} + (SCNT_W+1)'(push_acc)
                                   - (SCNT_W+1)'(sk_pop);
                        if (cnt_next != '0) begin
                            r_d.st    = ST_UNBLOCK;
                            r_d.stall = 1'b1;
                        end else begin
                            r_d.st    = (src_valid != '0) ? ST_RUN : ST_IDLE;
                            r_d.stall = 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, stall: 1'b0, ov: '0, od: '0};
        else        r_q <= r_d;
    end

    assign out_valid = r_q.ov;
    assign out_data  = r_q.od;
    assign dec_stall = r_q.stall;
    assign status    = r_q.st;
endmodule

// File: rtl/rn_stage_flow_chk.sv
module rn_stage_flow_chk #(
    parameter int LANES      = 4,
    parameter int SKID_DEPTH = 4,
    parameter int CNT_W      = 8,
    localparam int SCNT_W    = $clog2(SKID_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iew_stall,
    input logic              cmt_stall,
    input logic [CNT_W-1:0]  free_rob,
    input logic [CNT_W-1:0]  free_iq,
    input logic [CNT_W-1:0]  free_preg,
    input logic              squash,
    input logic              squash_busy,
    input logic [LANES-1:0]  out_valid,
    input logic              dec_stall,
    input logic [2:0]        status,
    input logic [SCNT_W-1:0] sk_cnt
);
    import rn_pkg::*;

    logic hold_st;
    assign hold_st = (status == ST_BLOCK) || (status == ST_UNBLOCK);

    AST_STALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall == hold_st); // R7

    AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        status == ST_BLOCK |-> out_valid == '0); // R5

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_IDLE || status == ST_RUN || status == ST_UNBLOCK) &&
        (iew_stall || cmt_stall) && !squash && !squash_busy
        |=> status == ST_BLOCK && out_valid == '0); // R3

    AST_UNBLOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        status == ST_BLOCK && !iew_stall && !cmt_stall && free_rob != '0 &&
        free_iq != '0 && !squash && !squash_busy
        |=> status == ST_UNBLOCK && dec_stall); // R6

    AST_SQUASH_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (squash || squash_busy) |=> status == ST_SQUASH && out_valid == '0); // R9

    AST_SQUASH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        status == ST_SQUASH && !squash && !squash_busy |=> status == ST_RUN); // R9

    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(out_valid) <= int'($past(free_preg))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sk_cnt <= SCNT_W'(SKID_DEPTH)); // R11
endmodule

bind rn_stage_flow rn_stage_flow_chk #(
    .LANES(LANES), .SKID_DEPTH(SKID_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iew_stall  (iew_stall),
    .cmt_stall  (cmt_stall),
    .free_rob   (free_rob),
    .free_iq    (free_iq),
    .free_preg  (free_preg),
    .squash     (squash),
    .squash_busy(squash_busy),
    .out_valid  (out_valid),
    .dec_stall  (dec_stall),
    .status     (status),
    .sk_cnt     (sk_cnt)
);

// File: tb/rn_stage_flow_tb.sv
module rn_stage_flow_tb;
    localparam int L = 4;
    localparam int D = 8;
    localparam int BUS = L * D;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [L-1:0]   dec_valid = '0;
    logic [BUS-1:0] dec_data = '0;
    logic           iew_stall = 1'b0, cmt_stall = 1'b0;
    logic [7:0]     free_rob = 8'd9, free_iq = 8'd9, free_preg = 8'd9;
    logic           squash = 1'b0, squash_busy = 1'b0;
    logic [L-1:0]   out_valid;
    logic [BUS-1:0] out_data;
    logic           dec_stall;
    logic [2:0]     status;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_BLK = 3'd2,
                           S_UNB = 3'd3, S_SQ = 3'd4;

    rn_stage_flow u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_data(dec_data),
        .iew_stall(iew_stall), .cmt_stall(cmt_stall), .free_rob(free_rob),
        .free_iq(free_iq), .free_preg(free_preg), .squash(squash),
        .squash_busy(squash_busy), .out_valid(out_valid), .out_data(out_data),
        .dec_stall(dec_stall), .status(status)
    );

    always #10 clk = ~clk;

    // {valid[4], rob[8], iq[8], preg[8], exp_valid[4], exp_status[3]}
    localparam int NV = 7;
    localparam logic [34:0] VEC [NV] = '{
        {4'hF, 8'd8,   8'd8,   8'd8,   4'hF, 3'd1},
        {4'h3, 8'd3,   8'd9,   8'd5,   4'h3, 3'd1},
        {4'h5, 8'd9,   8'd3,   8'd9,   4'h5, 3'd1},
        {4'h0, 8'd5,   8'd5,   8'd5,   4'h0, 3'd0},
        {4'h8, 8'd2,   8'd2,   8'd1,   4'h8, 3'd1},
        {4'hF, 8'd255, 8'd255, 8'd200, 4'hF, 3'd1},
        {4'h6, 8'd3,   8'd3,   8'd2,   4'h6, 3'd1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [BUS-1:0] keep(input logic [BUS-1:0] d, input logic [L-1:0] m);
        logic [BUS-1:0] r = '0;
        for (int i = 0; i < L; i++)
            if (m[i]) r[i*D +: D] = d[i*D +: D];
        return r;
    endfunction

    task automatic step(input logic [L-1:0] v, input logic [BUS-1:0] d,
                        input logic is, input logic cs, input logic [7:0] rob,
                        input logic [7:0] iq, input logic [7:0] pr,
                        input logic sq, input logic sb);
        @(negedge clk);
        dec_valid = v; dec_data = d; iew_stall = is; cmt_stall = cs;
        free_rob = rob; free_iq = iq; free_preg = pr; squash = sq; squash_busy = sb;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [L-1:0] v,
                              input logic [BUS-1:0] d, input logic [2:0] st,
                              input logic stl);
        chk({req, " valid"}, 64'(out_valid), 64'(v));
        chk({req, " data"}, 64'(out_data), 64'(keep(d, v)));
        chk({req, " status"}, 64'(status), 64'(st));
        chk({req, " stall"}, 64'(dec_stall), 64'(stl));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [BUS-1:0] x;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 status", 64'(status), 64'(S_IDLE));
        chk("R1 stall", 64'(dec_stall), 0);
        chk("R1 valid", 64'(out_valid), 0);

        // R2 / R10 table of release patterns
        for (int i = 0; i < NV; i++) begin
            logic [BUS-1:0] dd;
            dd = 32'h11223344 + 32'(i) * 32'h01030507;
            step(VEC[i][34:31], dd, 0, 0, VEC[i][30:23], VEC[i][22:15], VEC[i][14:7], 0, 0);
            expect_out("R2 R10 table", VEC[i][6:3], dd, VEC[i][2:0], 1'b0);
        end

        // R8 partial bundle: reorder-buffer credit 3 -> budget 2
        x = 32'hA1B2C3D4;
        step(4'hF, x, 0, 0, 8'd3, 8'd9, 8'd9, 0, 0);
        expect_out("R8 split first", 4'h3, x, S_UNB, 1'b1);
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R8 R7 split rest", 4'hC, x, S_RUN, 1'b0);

        // R3 / R5 / R6 / R7 stall, hold, unblock, replay
        step(4'hF, 32'h0F1E2D3C, 1, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R3 block on stall", 4'h0, '0, S_BLK, 1'b1);
        step(4'h3, 32'h55667788, 1, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R5 hold while blocked", 4'h0, '0, S_BLK, 1'b1);
        step(4'h0, '0, 0, 0, 8'd0, 8'd9, 8'd9, 0, 0);
        expect_out("R6 no unblock at zero rob", 4'h0, '0, S_BLK, 1'b1);
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R6 unblock", 4'h0, '0, S_UNB, 1'b1);
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R7 oldest first", 4'hF, 32'h0F1E2D3C, S_UNB, 1'b1);
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R7 drain to running", 4'h3, 32'h55667788, S_RUN, 1'b0);

        // R4 zero budget (adjusted rob = 0)
        step(4'h1, 32'h000000E7, 0, 0, 8'd1, 8'd9, 8'd9, 0, 0);
        expect_out("R4 block on no credit", 4'h0, '0, S_BLK, 1'b1);
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R4 unblock", 4'h0, '0, S_UNB, 1'b1);
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R4 replay", 4'h1, 32'h000000E7, S_RUN, 1'b0);

        // R9 squash discards stored and incoming work
        step(4'hF, 32'hDEADBEEF, 1, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R9 pre-block", 4'h0, '0, S_BLK, 1'b1);
        step(4'hF, 32'h12345678, 0, 0, 8'd9, 8'd9, 8'd9, 1, 0);
        expect_out("R9 squash enter", 4'h0, '0, S_SQ, 1'b0);
        step(4'hF, 32'h12345678, 0, 0, 8'd9, 8'd9, 8'd9, 0, 1);
        expect_out("R9 squash busy", 4'h0, '0, S_SQ, 1'b0);
        step(4'hF, 32'h12345678, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R9 squash exit", 4'h0, '0, S_RUN, 1'b0);
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R9 R10 no replay idle", 4'h0, '0, S_IDLE, 1'b0);

        // R11 four stored bundles under commit stall, replayed in order
        for (int k = 0; k < 4; k++) begin
            step(4'h1, 32'(8'h40 + 8'(k)), 0, 1, 8'd9, 8'd9, 8'd9, 0, 0);
            expect_out("R11 fill", 4'h0, '0, S_BLK, 1'b1);
        end
        step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
        expect_out("R11 unblock", 4'h0, '0, S_UNB, 1'b1);
        for (int k = 0; k < 4; k++) begin
            step(4'h0, '0, 0, 0, 8'd9, 8'd9, 8'd9, 0, 0);
            expect_out("R11 order", 4'h1, 32'(8'h40 + 8'(k)),
                       (k == 3) ? S_RUN : S_UNB, (k == 3) ? 1'b0 : 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule